// File: doc/BRIEF.md
# UART Register Front-End on an APB Slave Port

This block is the register side of a UART. A CPU reaches it over an APB slave port, and it exposes four registers: data, status, control and scaler. Bytes that have already been received come in on a byte stream with valid and ready handshakes. They are queued in a receive FIFO until software reads them out of the data register. When software writes the data register, the low byte goes out on a transmit byte stream as a one-cycle strobe, to be serialised by logic outside this block.

The control register decides whether receive and transmit are allowed. It also decides whether either kind of event pulses the single interrupt line. The other control bits (parity, flow control, loopback, clock source, FIFO interrupts, debug, output enable, FIFO-present) are only stored and read back. The status register reports:

- whether receive data is waiting,
- receive FIFO half and full,
- transmit FIFO empty and shift register empty, which are always set because the transmit path never backs up.

The error flags read as zero.

Top module: `uart_reg_frontend`

## Requirements
- R1: After reset the control register reads 0, the receive FIFO is empty, and the status register reads 0x0000_0006.
- R2: Control (offset 0x08) is 32 bits wide, fully writable, and reads back exactly the value last written.
- R3: A write to status (offset 0x04) has no effect. Status bits 1 (transmit shift empty) and 2 (transmit FIFO empty) always read 1. Bits 3..7, bit 9 and bits 11..31 always read 0.
- R4: The scaler (0x0C), offsets 0x01, 0x02, 0x10 and every other offset not listed here read 0. Writes to them change no register.
- R5: An input byte (rx_valid_i high while rx_ready_o is high) enters the FIFO only when control bit 0 is 1. Otherwise it is consumed and dropped.
- R6: A read of offset 0x00 or 0x03 returns the oldest FIFO byte in bits 7..0, with zeros above it, and removes that byte. Bytes come out in arrival order. A pop and a push in the same cycle are both honoured.
- R7: Status bit 0 is 1 exactly while the FIFO holds at least one byte. A data read from an empty FIFO returns 0 and changes nothing.
- R8: rx_ready_o is low exactly while the FIFO holds DEPTH bytes. Status bit 10 is 1 in that state. Status bit 8 is 1 while the FIFO holds at least DEPTH/2 bytes.
- R9: A write to offset 0x00 or 0x03 while control bit 1 is 1 drives pwdata_i[7:0] on tx_data_o. tx_valid_o is high for exactly the one cycle after the access phase. With control bit 1 at 0, or at any other offset, tx_valid_o stays low.
- R10: irq_o is high for the single cycle after a byte is accepted while control bit 2 is 1, or after a byte is transmitted while control bit 3 is 1. At no other time is it high.
- R11: pready_o is always 1 and pslverr_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | ADDR_W | APB byte address, low 8 bits decoded |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always 1 |
| pslverr_o | output | 1 | APB error, always 0 |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_ready_o | output | 1 | Receive FIFO can take a byte |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | One-cycle transmit strobe |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with DEPTH = 4 and ADDR_W = 8. The small depth makes the half threshold (2 bytes), the full state, the dropped byte while full and the deassertion of rx_ready_o reachable in a few transfers. It also lets a pop and a push coincide at several fill levels. With the default depth of 16 the same logic only reaches these states after long fills.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  localparam logic [7:0] OFS_DATA   = 8'h00;
  localparam logic [7:0] OFS_DATA_B = 8'h03;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_SCAL   = 8'h0C;

  // control bit positions
  localparam int CB_RX_EN = 0;
  localparam int CB_TX_EN = 1;
  localparam int CB_RX_IE = 2;
  localparam int CB_TX_IE = 3;

  // status bit positions
  localparam int SB_DREADY   = 0;
  localparam int SB_TX_SH_MT = 1;
  localparam int SB_TX_FF_MT = 2;
  localparam int SB_RX_HALF  = 8;
  localparam int SB_RX_FULL  = 10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_SCAL
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [7:0] a);
    reg_sel_e s;
    case (a)
      OFS_DATA, OFS_DATA_B: s = SEL_DATA;
      OFS_STAT:             s = SEL_STAT;
      OFS_CTRL:             s = SEL_CTRL;
      OFS_SCAL:             s = SEL_SCAL;
      default:              s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/uart_fe_rx_fifo.sv
module uart_fe_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = mem_q[rd_ptr_q];
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int HALF  = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  input  logic [7:0]        rx_head_i,
  input  logic [CNT_W-1:0]  rx_cnt_i,
  output logic [31:0]       prdata_o,
  output logic [31:0]       ctrl_o,
  output logic              rx_pop_o,
  output logic              tx_req_o,
  output logic [7:0]        tx_byte_o
);

  reg_sel_e    sel;
  logic        access;
  logic [31:0] ctrl_q;
  logic [31:0] status;
  logic [31:0] rdata;

  assign sel    = decode_sel(paddr_i[7:0]);
  assign access = psel_i && penable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ctrl_q <= '0;
    else if (access && pwrite_i && sel == SEL_CTRL) ctrl_q <= pwdata_i;
  end

  always_comb begin
    status              = '0;
    status[SB_DREADY]   = (rx_cnt_i != '0);
    status[SB_TX_SH_MT] = 1'b1;
    status[SB_TX_FF_MT] = 1'b1;
    status[SB_RX_HALF]  = (rx_cnt_i >= CNT_W'(HALF));
    status[SB_RX_FULL]  = (rx_cnt_i == CNT_W'(DEPTH));
  end

  always_comb begin
    case (sel)
      SEL_DATA: rdata = (rx_cnt_i != '0) ? {24'h0, rx_head_i} : '0;
      SEL_STAT: rdata = status;
      SEL_CTRL: rdata = ctrl_q;
      default:  rdata = '0;
    endcase
  end

  assign prdata_o  = (psel_i && !pwrite_i) ? rdata : '0;
  assign ctrl_o    = ctrl_q;
  assign rx_pop_o  = access && !pwrite_i && (sel == SEL_DATA);
  assign tx_req_o  = access && pwrite_i && (sel == SEL_DATA) && ctrl_q[CB_TX_EN];
  assign tx_byte_o = pwdata_i[7:0];

endmodule

// File: rtl/uart_fe_events.sv
module uart_fe_events (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_accept_i,
  input  logic       rx_ie_i,
  input  logic       tx_req_i,
  input  logic       tx_ie_i,
  input  logic [7:0] tx_byte_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  output logic       irq_o
);

  logic       tx_valid_q, irq_q;
  logic [7:0] tx_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
      irq_q      <= 1'b0;
    end else begin
      tx_valid_q <= tx_req_i;
      if (tx_req_i) tx_data_q <= tx_byte_i;
      irq_q <= (rx_accept_i && rx_ie_i) || (tx_req_i && tx_ie_i);
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_data_o  = tx_data_q;
  assign irq_o      = irq_q;

endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              irq_o
);

  logic [31:0]      ctrl;
  logic [7:0]       rx_head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             rx_pop, rx_accept, tx_req;
  logic [7:0]       tx_byte;

  assign rx_ready_o = (fifo_cnt != CNT_W'(DEPTH));
  assign rx_accept  = rx_valid_i && rx_ready_o && ctrl[CB_RX_EN];
  assign pready_o   = 1'b1;
  assign pslverr_o  = 1'b0;

  uart_fe_rx_fifo #(.DEPTH(DEPTH), .W(8)) fifo_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rx_accept),
    .din_i  (rx_data_i),
    .pop_i  (rx_pop),
    .head_o (rx_head),
    .cnt_o  (fifo_cnt)
  );

  uart_fe_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pwdata_i  (pwdata_i),
    .rx_head_i (rx_head),
    .rx_cnt_i  (fifo_cnt),
    .prdata_o  (prdata_o),
    .ctrl_o    (ctrl),
    .rx_pop_o  (rx_pop),
    .tx_req_o  (tx_req),
    .tx_byte_o (tx_byte)
  );

  uart_fe_events evt_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_accept_i (rx_accept),
    .rx_ie_i     (ctrl[CB_RX_IE]),
    .tx_req_i    (tx_req),
    .tx_ie_i     (ctrl[CB_TX_IE]),
    .tx_byte_i   (tx_byte),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/uart_reg_frontend_chk.sv
module uart_reg_frontend_chk #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [31:0]       prdata_o,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic              irq_o,
  input logic [31:0]       ctrl,
  input logic [CNT_W-1:0]  fifo_cnt
);

  logic dsel, acc;
  assign dsel = (paddr_i[7:0] == 8'h00) || (paddr_i[7:0] == 8'h03);
  assign acc  = psel_i && penable_i;

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (ctrl == '0 && fifo_cnt == '0);
    end
  end

  // R9
  tx_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> $past(acc && pwrite_i && dsel && ctrl[1]));

  // R9
  tx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |=> !tx_valid_o);

  // R10
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past((rx_valid_i && rx_ready_o && ctrl[0] && ctrl[2]) ||
                    (acc && pwrite_i && dsel && ctrl[1] && ctrl[3])));

  // R8
  full_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == CNT_W'(DEPTH)) |-> !rx_ready_o);

  // R7
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !pwrite_i && dsel && fifo_cnt == '0) |-> (prdata_o == '0));

endmodule

bind uart_reg_frontend uart_reg_frontend_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .psel_i     (psel_i),
  .penable_i  (penable_i),
  .pwrite_i   (pwrite_i),
  .paddr_i    (paddr_i),
  .prdata_o   (prdata_o),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .irq_o      (irq_o),
  .ctrl       (ctrl),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/uart_reg_frontend_tb.sv
`timescale 1ns/1ps
module uart_reg_frontend_tb_top;

  localparam int DEPTH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr;
  logic [7:0]  rx_data, tx_data;
  logic        rx_valid, rx_ready, tx_valid, irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  uart_reg_frontend #(.ADDR_W(8), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .irq_o(irq)
  );

  // reference model
  logic [7:0]  m_q[$];
  logic [31:0] m_ctrl;
  logic        m_tx_v, m_irq;
  logic [7:0]  m_tx_d;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q.delete();
      m_ctrl = '0; m_tx_v = 1'b0; m_tx_d = '0; m_irq = 1'b0;
    end else begin
      logic acc, dsel, push, txe;
      acc  = psel && penable;
      dsel = (paddr == 8'h00) || (paddr == 8'h03);
      push = rx_valid && (m_q.size() < DEPTH) && m_ctrl[0];
      txe  = acc && pwrite && dsel && m_ctrl[1];
      if (acc && !pwrite && dsel && m_q.size() > 0) void'(m_q.pop_front());
      if (push) m_q.push_back(rx_data);
      m_irq  = (push && m_ctrl[2]) || (txe && m_ctrl[3]);
      m_tx_v = txe;
      if (txe) m_tx_d = pwdata[7:0];
      if (acc && pwrite && paddr == 8'h08) m_ctrl = pwdata;
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [7:0] a);
    logic [31:0] r;
    int n;
    n = m_q.size();
    r = '0;
    case (a)
      8'h00, 8'h03: r = (n > 0) ? {24'h0, m_q[0]} : '0;
      8'h04: begin
        r[0] = (n > 0); r[1] = 1'b1; r[2] = 1'b1;
        r[8] = (n >= DEPTH / 2); r[10] = (n == DEPTH);
      end
      8'h08: r = m_ctrl;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R9 tx_valid", {31'b0, tx_valid}, {31'b0, m_tx_v});
      if (m_tx_v) check("R9 tx_data", {24'b0, tx_data}, {24'b0, m_tx_d});
      check("R10 irq", {31'b0, irq}, {31'b0, m_irq});
      check("R8 rx_ready", {31'b0, rx_ready}, {31'b0, (m_q.size() < DEPTH)});
      check("R11 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk_i); #1;
    penable = 1'b1;
    @(posedge clk_i); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input string tag, input logic [7:0] a, output logic [31:0] d);
    @(posedge clk_i); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk_i); #1;
    penable = 1'b1;
    @(negedge clk_i);
    d = prdata;
    check(tag, prdata, exp_rdata(a));
    @(posedge clk_i); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(posedge clk_i); #1;
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk_i); #1;
    rx_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    logic [31:0] d;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    rx_valid = 0; rx_data = 0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    apb_rd("R1 status", 8'h04, d);  check("R1 status value", d, 32'h6);
    apb_rd("R1 ctrl", 8'h08, d);    check("R1 ctrl value", d, 32'h0);
    apb_rd("R7 empty read", 8'h00, d); check("R7 empty data", d, 32'h0);

    // R2 control readback
    apb_wr(8'h08, 32'hFFFF_FFF0);
    apb_rd("R2 ctrl", 8'h08, d);    check("R2 ctrl all", d, 32'hFFFF_FFF0);
    apb_wr(8'h08, 32'h8000_1A50);
    apb_rd("R2 ctrl", 8'h08, d);    check("R2 ctrl pattern", d, 32'h8000_1A50);
    apb_wr(8'h08, 32'h0);

    // R3 status read-only
    apb_wr(8'h04, 32'hFFFF_FFFF);
    apb_rd("R3 status", 8'h04, d);  check("R3 status after write", d, 32'h6);

    // R4 scaler / unknown
    apb_wr(8'h0C, 32'h1234_5678);
    apb_wr(8'h10, 32'hFFFF_FFFF);
    apb_wr(8'h01, 32'h0000_0007);
    apb_rd("R4 scaler", 8'h0C, d);  check("R4 scaler zero", d, 0);
    apb_rd("R4 0x10", 8'h10, d);    check("R4 debug zero", d, 0);
    apb_rd("R4 0x02", 8'h02, d);    check("R4 off2 zero", d, 0);
    apb_rd("R4 0x14", 8'h14, d);    check("R4 off14 zero", d, 0);
    apb_rd("R4 ctrl", 8'h08, d);    check("R4 ctrl untouched", d, 0);

    // R5 receive disabled drops bytes
    send_rx(8'h5A);
    apb_rd("R5 status", 8'h04, d);  check("R5 no data ready", d, 32'h6);

    // R5/R6/R10 receive enabled with interrupt
    apb_wr(8'h08, 32'h5);
    send_rx(8'hA1); send_rx(8'hB2); send_rx(8'hC3);
    apb_rd("R8 status half", 8'h04, d); check("R8 half set", d, 32'h107);
    apb_rd("R6 data b3", 8'h03, d);  check("R6 first", d, 32'hA1);
    apb_rd("R6 data b0", 8'h00, d);  check("R6 second", d, 32'hB2);

    // R8 fill to full
    send_rx(8'hD4); send_rx(8'hE5); send_rx(8'hF6);
    apb_rd("R8 status full", 8'h04, d); check("R8 full set", d, 32'h507);
    send_rx(8'h77);   // dropped, FIFO full
    apb_rd("R6 data", 8'h00, d);     check("R6 third", d, 32'hC3);
    apb_rd("R6 data", 8'h00, d);     check("R6 fourth", d, 32'hD4);
    apb_rd("R6 data", 8'h00, d);     check("R6 fifth", d, 32'hE5);
    apb_rd("R6 data", 8'h00, d);     check("R8 full drop", d, 32'hF6);
    apb_rd("R7 status", 8'h04, d);   check("R7 ready cleared", d, 32'h6);
    apb_rd("R7 empty", 8'h00, d);    check("R7 empty zero", d, 0);

    // R6 simultaneous pop and push
    send_rx(8'h11);
    fork
      apb_rd("R6 concurrent", 8'h00, d);
      begin @(posedge clk_i); send_rx(8'h22); end
    join
    check("R6 concurrent pop", d, 32'h11);
    apb_rd("R7 status", 8'h04, d);   check("R7 still ready", d, 32'h7);
    apb_rd("R6 data", 8'h00, d);     check("R6 after concurrent", d, 32'h22);

    // R9 transmit
    apb_wr(8'h08, 32'h0);
    apb_wr(8'h00, 32'h0000_0099);    // disabled: no strobe
    apb_wr(8'h08, 32'h2);
    apb_wr(8'h00, 32'hFFFF_FF3C);
    apb_wr(8'h03, 32'h0000_0042);
    apb_wr(8'h01, 32'h0000_0055);    // wrong offset: no strobe
    apb_wr(8'h08, 32'hA);            // R10 with tx interrupt
    apb_wr(8'h00, 32'h0000_00E7);
    apb_wr(8'h08, 32'hF);
    send_rx(8'h01);
    apb_wr(8'h03, 32'h0000_0002);
    apb_rd("R6 data", 8'h00, d);     check("R6 last", d, 32'h01);

    repeat (4) @(posedge clk_i);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule